// File: doc/BRIEF.md
# TDM Serial Input Offset Aligner

The block takes one serial time-division-multiplexed input line and a frame pulse, and turns the line into 8-bit timeslot bytes. Software-style configuration inputs decide where each bit is sampled: a whole-clock offset from the frame pulse, an extra half clock, the number of clocks per bit, and whether a timeslot arrives most or least significant bit first. At the end of every timeslot the block presents the byte, its channel number within the frame and a one-cycle valid strobe.

The frame is `SLOTS_HI * 8` clocks long at every rate. At the fastest rate each clock carries one bit and the frame holds `SLOTS_HI` slots; each slower rate doubles the clocks per bit and halves the slot count. The configuration inputs are expected to stay fixed while reset is released; they are changed only under reset.

Top module: `tdm_offset_aligner`

## Requirements
- R1: After reset `byte_valid`, `byte_data` and `byte_chan` are 0, and no byte is emitted before the first frame pulse has been seen.
- R2: `frame_n` is active low and sampled on the rising clock edge; with `offset` 0 and `half_en` 0 the cell of frame bit 0 begins in the cycle right after the cycle in which `frame_n` is low.
- R3: `offset` (0 to 7) moves every bit cell later by that many whole clock cycles.
- R4: With `half_en` 1 every sample is taken on the falling edge half a clock after the rising edge that would be used with `half_en` 0.
- R5: `rate_sel` 0, 1, 2, 3 gives 1, 2, 4, 8 clocks per bit, and the bit is sampled at clock 0, 1, 3, 6 of its cell (counted from 0), the three-quarter point at the slower rates.
- R6: With `lsb_first` 0 the first bit received in a slot becomes `byte_data[7]` and the last becomes `byte_data[0]`.
- R7: With `lsb_first` 1 the first bit received in a slot becomes `byte_data[0]` and the last becomes `byte_data[7]`.
- R8: `byte_valid` is high for exactly one cycle, the cycle after the eighth bit of a slot is captured; `byte_chan` is the slot number, counting from 0 and wrapping at `SLOTS_HI >> rate_sel`; `byte_data` and `byte_chan` change only when `byte_valid` is high.
- R9: Once aligned the block keeps framing on its own; if later frame pulses are missing, slots keep coming at the same places in every following frame.
- R10: After the first frame pulse the first byte emitted is slot 0 of that frame; bit positions that fall before the offset start are not assembled into a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame start pulse, active low, one cycle |
| din | input | 1 | Serial TDM data |
| rate_sel | input | 2 | Clocks per bit: 0=1, 1=2, 2=4, 3=8 |
| lsb_first | input | 1 | 1: slot bits arrive bit 0 first; 0: bit 7 first |
| offset | input | 3 | Whole-clock delay of the bit cells |
| half_en | input | 1 | Adds a half-clock delay to the sample point |
| byte_valid | output | 1 | One-cycle strobe for a finished slot |
| byte_data | output | 8 | Assembled slot byte |
| byte_chan | output | log2(SLOTS_HI) | Channel number of the slot |

## Verification
The hardest point to reach is the half-clock delay: if the input only changes on rising edges, a falling-edge sample equals the next rising-edge sample and a wrong edge goes unnoticed. The bench therefore drives a new data value on both clock edges, so each half period carries its own bit, and predicts every byte from the half-period index of the sample. Large offsets push the last slot of one frame past the next frame pulse, and a run with the later pulses withheld shows the framing carries on alone.

// File: rtl/tdm_offset_aligner.sv
module tdm_offset_aligner #(
  parameter int SLOTS_HI = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_n,
  input  logic                          din,
  input  logic [1:0]                    rate_sel,
  input  logic                          lsb_first,
  input  logic [2:0]                    offset,
  input  logic                          half_en,
  output logic                          byte_valid,
  output logic [7:0]                    byte_data,
  output logic [$clog2(SLOTS_HI)-1:0]   byte_chan
);
  localparam int FRAME = SLOTS_HI * 8;
  localparam int PW    = $clog2(FRAME);
  localparam int CW    = PW - 3;

  logic [PW-1:0] pos, rel, bitn;
  logic          synced, armed, neg_q, hit_d;
  logic [2:0]    bit_d, mask, phase, sp;
  logic [CW-1:0] slot_d;
  logic [7:0]    shreg, nxt;
  logic          start, live, hit, cap, cd;
  logic [2:0]    cb;
  logic [CW-1:0] cs;

  always_comb begin
    case (rate_sel)
      2'd0:    sp = 3'd0;
      2'd1:    sp = 3'd1;
      2'd2:    sp = 3'd3;
      default: sp = 3'd6;
    endcase
  end

  assign rel   = pos - PW'(offset);
  assign bitn  = rel >> rate_sel;
  assign mask  = 3'((4'd1 << rate_sel) - 4'd1);
  assign phase = rel[2:0] & mask;
  assign start = synced && (rel == '0);
  assign live  = armed || start;
  assign hit   = live && (phase == sp);

  assign cap = half_en ? hit_d  : hit;
  assign cb  = half_en ? bit_d  : bitn[2:0];
  assign cs  = half_en ? slot_d : bitn[PW-1:3];
  assign cd  = half_en ? neg_q  : din;
  assign nxt = lsb_first ? {cd, shreg[7:1]} : {shreg[6:0], cd};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      synced     <= 1'b0;
      armed      <= 1'b0;
      hit_d      <= 1'b0;
      bit_d      <= '0;
      slot_d     <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_chan  <= '0;
    end else begin
      if (!frame_n) begin
        pos    <= '0;
        synced <= 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
      if (start) armed <= 1'b1;
      hit_d      <= hit;
      bit_d      <= bitn[2:0];
      slot_d     <= bitn[PW-1:3];
      byte_valid <= 1'b0;
      if (cap) begin
        shreg <= nxt;
        if (cb == 3'd7) begin
          byte_valid <= 1'b1;
          byte_data  <= nxt;
          byte_chan  <= cs;
        end
      end
    end
  end

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  a_r8_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ({1'b0, byte_chan} < (CW+1)'(SLOTS_HI >> rate_sel)));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> ($stable(byte_data) && $stable(byte_chan)));

  a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !byte_valid);
endmodule

// File: tb/tb_tdm_offset_aligner.sv
`timescale 1ns/100ps
module tb_tdm_offset_aligner;
  localparam int SL    = 8;
  localparam int FRAME = SL * 8;
  localparam int CW    = $clog2(SL);
  localparam int NRUN  = 3 * FRAME + 20;
  localparam int HN    = 2 * NRUN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic din = 1'b0;
  logic [1:0] rate_sel = '0;
  logic lsb_first = 1'b0;
  logic [2:0] offset = '0;
  logic half_en = 1'b0;
  logic byte_valid;
  logic [7:0] byte_data;
  logic [CW-1:0] byte_chan;

  tdm_offset_aligner #(.SLOTS_HI(SL)) dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .din(din),
    .rate_sel(rate_sel), .lsb_first(lsb_first), .offset(offset),
    .half_en(half_en), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_chan(byte_chan));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int ev_n   = 0;
  int ev_byte [0:63];
  int ev_chan [0:63];
  int ev_cyc  [0:63];
  logic hv [0:HN-1];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    #2;
    if (byte_valid && ev_n < 64) begin
      ev_byte[ev_n] = byte_data;
      ev_chan[ev_n] = byte_chan;
      ev_cyc[ev_n]  = cyc;
      ev_n++;
    end
  end

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input int rate, input bit lsb, input int off,
                          input bit half, input bit all_pulses, input string tag);
    int f0, cpb, sp, slots;
    rst_n = 1'b0; frame_n = 1'b1;
    rate_sel = 2'(rate); lsb_first = lsb; offset = 3'(off); half_en = half;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check(byte_valid == 1'b0 && byte_data == 8'd0 && byte_chan == '0, "R1",
          "reset outputs", {byte_valid, byte_data}, 0);
    for (int i = 0; i < HN; i++) hv[i] = next_bit();
    ev_n = 0;
    for (int p = 0; p < 5; p++) begin
      @(posedge clk); #1 din = next_bit();
      @(negedge clk); #1 din = next_bit();
    end
    f0 = 0;
    for (int n = 0; n < NRUN; n++) begin
      @(posedge clk); #1;
      if (n == 0) f0 = cyc;
      frame_n = ((n % FRAME == 0) && (all_pulses || n == 0) && n < 3 * FRAME) ? 1'b0 : 1'b1;
      din = (n >= 1) ? hv[2 * (n - 1)] : next_bit();
      @(negedge clk); #1;
      din = (n >= 1) ? hv[2 * (n - 1) + 1] : next_bit();
    end
    cpb   = 1 << rate;
    sp    = (rate == 0) ? 0 : (rate == 1) ? 1 : (rate == 2) ? 3 : 6;
    slots = SL >> rate;
    check(ev_n >= 2 * slots, tag, "byte count", ev_n, 2 * slots);
    if (ev_n > 0)
      check(ev_cyc[0] == f0 + 2 + off + 7 * cpb + sp + int'(half), "R10",
            "first byte cycle", ev_cyc[0], f0 + 2 + off + 7 * cpb + sp + int'(half));
    for (int f = 0; f < 2; f++) begin
      for (int j = 0; j < slots; j++) begin
        int e, idx, eb, ec;
        e  = f * slots + j;
        eb = 0; idx = 0;
        for (int b = 0; b < 8; b++) begin
          idx = f * FRAME + off + (j * 8 + b) * cpb + sp;
          if (hv[2 * idx + 1 + int'(half)]) eb |= lsb ? (1 << b) : (1 << (7 - b));
        end
        ec = f0 + 2 + idx + int'(half);
        if (e < ev_n) begin
          check(ev_byte[e] == eb, tag, "byte value", ev_byte[e], eb);
          check(ev_chan[e] == j, "R8", "channel", ev_chan[e], j);
          check(ev_cyc[e] == ec, tag, "strobe cycle", ev_cyc[e], ec);
        end
      end
    end
  endtask

  task automatic t_default();   run_case(0, 0, 0, 0, 1, "R2");  endtask
  task automatic t_offset();    run_case(0, 0, 3, 0, 1, "R3");  endtask
  task automatic t_half_lsb();  run_case(0, 1, 0, 1, 1, "R4");  endtask
  task automatic t_lsb_order(); run_case(0, 1, 6, 0, 1, "R7");  endtask
  task automatic t_msb_order(); run_case(1, 0, 2, 0, 1, "R6");  endtask
  task automatic t_rate_2clk(); run_case(1, 0, 5, 1, 1, "R5");  endtask
  task automatic t_rate_4clk(); run_case(2, 1, 7, 0, 1, "R5");  endtask
  task automatic t_rate_8clk(); run_case(3, 0, 4, 1, 1, "R5");  endtask
  task automatic t_freerun();   run_case(0, 0, 7, 1, 0, "R9");  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_default();
    t_offset();
    t_half_lsb();
    t_lsb_order();
    t_msb_order();
    t_rate_2clk();
    t_rate_4clk();
    t_rate_8clk();
    t_freerun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule